// File: doc/BRIEF.md
# Command Word Collector and Dispatcher

The block sits behind two write-only registers of a storage controller's host interface. Software first writes a command identifier, then writes that command's parameter block one 32-bit word at a time. Each command has a fixed parameter size in bytes. The block stores the words in arrival order until the stored bytes cover that size. It then offers the command code and the stored words to a handler over a valid/ready dispatch channel. When the handler accepts, the block captures the handler's result into the readable command status and returns to its idle state.

The dispatch check runs right after a command write and again after every stored word. A command with no parameters is therefore offered to its handler one cycle after it is written. An identifier outside the legal range selects an internal idle pseudo-command. The idle pseudo-command never reaches the handler. It fails at once, both on its own command write and on any data word written while it is current.

Back-pressure: `disp_valid` stays high and `disp_code`, `disp_nwords` and `disp_words` stay stable until a cycle with `disp_ready` high. `disp_result` is sampled in that cycle. Register writes cannot be stalled. A write of either register while a dispatch is waiting is dropped and flagged on `wr_err`.

Top module: `cmd_dispatch`

## Requirements
- R1: After reset `cmd_status` is 0 (succeeded), `disp_valid` is 0, `wr_err` is 0, and the idle pseudo-command is current with no words stored.
- R2: A command write with an identifier from 1 to 9 makes that command current, clears the word count and sets `cmd_status` to 32'hFFFF_FFFF (more data needed) on the next cycle.
- R3: A command write with identifier 0 or any value of 10 or more selects the idle pseudo-command and sets `cmd_status` to 1 (failed) on the next cycle, with no dispatch.
- R4: Commands whose parameter size is zero are offered on the dispatch channel on the cycle after their write, with `disp_nwords` = 0.
- R5: After each stored word the block dispatches once (words × 4) ≥ the parameter bytes of the current command. Parameter bytes per identifier: 1 → 24, 2, 3, 6 and 8 → 0, 4 → RING_BYTES (default 80), 5 → 12, 7 → MSG_BYTES (default 20), 9 → 12. Word k sits in `disp_words[32k +: 32]`, and `disp_nwords` gives the stored count.
- R6: While `disp_valid` is high and `disp_ready` is low, the dispatch outputs hold their values.
- R7: On a dispatch handshake `cmd_status` takes `disp_result` on the next cycle, `disp_valid` falls, and the idle pseudo-command becomes current with a zero count.
- R8: A data word written while the idle pseudo-command is current is not stored, produces no dispatch, and sets `cmd_status` to 1 on the next cycle.
- R9: A command or data write while a dispatch waits is dropped: `wr_err` pulses high for one cycle, and the dispatch outputs and `cmd_status` are unchanged.
- R10: A command write in the middle of collection discards the words already stored. The new command counts its words from zero.
- R11: When a command write and a data write arrive in the same cycle, the command write takes effect and the data word is discarded without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_id | input | ID_W | Command identifier written |
| dat_wr | input | 1 | Data register write strobe |
| dat_word | input | 32 | Parameter word written |
| disp_valid | output | 1 | Dispatch offered to handler |
| disp_ready | input | 1 | Handler accepts dispatch and presents result |
| disp_code | output | ID_W | Command being dispatched |
| disp_nwords | output | CNT_W | Number of stored words |
| disp_words | output | BUF_WORDS*32 | Stored words, word 0 in the low bits |
| disp_result | input | 32 | Handler result, sampled on handshake |
| cmd_status | output | 32 | Readable command status |
| wr_err | output | 1 | One-cycle pulse for a dropped write |

## Verification
The bench probes the exact dispatch threshold. For the six-word command it checks that nothing is offered after the fifth word and that the offer comes after the sixth. For the largest command it checks that the last buffer slot is filled. An off-by-one compare would dispatch early or strand the command. Zero-payload and out-of-range identifiers are written to catch a design that waits for data that never comes, or that hands the idle code to the handler. Writes made while a dispatch is held under back-pressure, a restart in mid-collection, and a simultaneous command-and-data write are checked for corrupted stored words, a missing error pulse, or a count that survives the restart.

// File: rtl/cmdc_pkg.sv
package cmdc_pkg;
  localparam int WORD_W = 32;

  // command identifiers; the numeric codes are seen by software
  localparam int OP_IDLE      = 0;
  localparam int OP_CONFIG    = 1;
  localparam int OP_ISSUE     = 2;
  localparam int OP_UNPLUG    = 3;
  localparam int OP_RING_SET  = 4;
  localparam int OP_DEV_RESET = 5;
  localparam int OP_BUS_RESET = 6;
  localparam int OP_MSG_SET   = 7;
  localparam int OP_ADP_RESET = 8;
  localparam int OP_ABORT     = 9;
  localparam int OP_LIMIT     = 10;

  localparam logic [WORD_W-1:0] ST_OK    = 32'h0000_0000;
  localparam logic [WORD_W-1:0] ST_FAIL  = 32'h0000_0001;
  localparam logic [WORD_W-1:0] ST_SHORT = 32'hFFFF_FFFF;

  typedef enum logic [0:0] {PH_COLLECT = 1'b0, PH_WAIT = 1'b1} phase_e;
endpackage

// File: rtl/cmdc_need.sv
module cmdc_need #(
  parameter int ID_W         = 8,
  parameter int LEN_W        = 16,
  parameter int CFG_BYTES    = 24,
  parameter int RING_BYTES   = 80,
  parameter int MSG_BYTES    = 20,
  parameter int DEVRST_BYTES = 12,
  parameter int ABORT_BYTES  = 12
) (
  input  logic [ID_W-1:0]  code,
  output logic [LEN_W-1:0] need_bytes
);
  import cmdc_pkg::*;

  always_comb begin
    case (code)
      ID_W'(OP_CONFIG):    need_bytes = LEN_W'(CFG_BYTES);
      ID_W'(OP_RING_SET):  need_bytes = LEN_W'(RING_BYTES);
      ID_W'(OP_DEV_RESET): need_bytes = LEN_W'(DEVRST_BYTES);
      ID_W'(OP_MSG_SET):   need_bytes = LEN_W'(MSG_BYTES);
      ID_W'(OP_ABORT):     need_bytes = LEN_W'(ABORT_BYTES);
      default:             need_bytes = '0;
    endcase
  end
endmodule

// File: rtl/cmdc_wordbuf.sv
module cmdc_wordbuf #(
  parameter int DEPTH  = 20,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        widx,
  input  logic [WORD_W-1:0]       wdata,
  output logic [DEPTH*WORD_W-1:0] flat
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          slot_q <= '0;
      else if (we && widx == IDX_W'(g))    slot_q <= wdata;
    end
    assign flat[g*WORD_W +: WORD_W] = slot_q;
  end
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch #(
  parameter int ID_W         = 8,
  parameter int CFG_BYTES    = 24,
  parameter int RING_BYTES   = 80,
  parameter int MSG_BYTES    = 20,
  parameter int DEVRST_BYTES = 12,
  parameter int ABORT_BYTES  = 12,
  localparam int LEN_W       = 16,
  localparam int MAX_A       = (CFG_BYTES > RING_BYTES) ? CFG_BYTES : RING_BYTES,
  localparam int MAX_B       = (MSG_BYTES > DEVRST_BYTES) ? MSG_BYTES : DEVRST_BYTES,
  localparam int MAX_C       = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int MAX_BYTES   = (MAX_C > ABORT_BYTES) ? MAX_C : ABORT_BYTES,
  localparam int BUF_WORDS   = (MAX_BYTES + 3) / 4,
  localparam int CNT_W       = $clog2(BUF_WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_wr,
  input  logic [ID_W-1:0]         cmd_id,
  input  logic                    dat_wr,
  input  logic [31:0]             dat_word,
  output logic                    disp_valid,
  input  logic                    disp_ready,
  output logic [ID_W-1:0]         disp_code,
  output logic [CNT_W-1:0]        disp_nwords,
  output logic [BUF_WORDS*32-1:0] disp_words,
  input  logic [31:0]             disp_result,
  output logic [31:0]             cmd_status,
  output logic                    wr_err
);
  import cmdc_pkg::*;

  phase_e            phase_q;
  logic [ID_W-1:0]   cur_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       status_q;
  logic              err_q;

  logic [LEN_W-1:0]  in_need, cur_need;
  logic              in_known, cur_idle, enough, store_en;
  logic [CNT_W-1:0]  cnt_inc;

  cmdc_need #(
    .ID_W(ID_W), .LEN_W(LEN_W), .CFG_BYTES(CFG_BYTES), .RING_BYTES(RING_BYTES),
    .MSG_BYTES(MSG_BYTES), .DEVRST_BYTES(DEVRST_BYTES), .ABORT_BYTES(ABORT_BYTES)
  ) u_need_in (.code(cmd_id), .need_bytes(in_need));

  cmdc_need #(
    .ID_W(ID_W), .LEN_W(LEN_W), .CFG_BYTES(CFG_BYTES), .RING_BYTES(RING_BYTES),
    .MSG_BYTES(MSG_BYTES), .DEVRST_BYTES(DEVRST_BYTES), .ABORT_BYTES(ABORT_BYTES)
  ) u_need_cur (.code(cur_q), .need_bytes(cur_need));

  assign in_known = (cmd_id > ID_W'(OP_IDLE)) && (cmd_id < ID_W'(OP_LIMIT));
  assign cur_idle = (cur_q == ID_W'(OP_IDLE));
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign enough   = (LEN_W'(cnt_inc) << 2) >= cur_need;
  assign store_en = (phase_q == PH_COLLECT) && !cmd_wr && dat_wr && !cur_idle;

  cmdc_wordbuf #(
    .DEPTH(BUF_WORDS), .WORD_W(32), .IDX_W(CNT_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .we(store_en), .widx(cnt_q),
    .wdata(dat_word), .flat(disp_words)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_COLLECT;
      cur_q    <= ID_W'(OP_IDLE);
      cnt_q    <= '0;
      status_q <= ST_OK;
      err_q    <= 1'b0;
    end else begin
      err_q <= (phase_q == PH_WAIT) && (cmd_wr || dat_wr);
      if (phase_q == PH_WAIT) begin
        if (disp_ready) begin
          status_q <= disp_result;
          cur_q    <= ID_W'(OP_IDLE);
          cnt_q    <= '0;
          phase_q  <= PH_COLLECT;
        end
      end else if (cmd_wr) begin
        cnt_q <= '0;
        if (in_known) begin
          cur_q    <= cmd_id;
          status_q <= ST_SHORT;
          if (in_need == '0) phase_q <= PH_WAIT;
        end else begin
          cur_q    <= ID_W'(OP_IDLE);
          status_q <= ST_FAIL;
        end
      end else if (dat_wr) begin
        if (cur_idle) begin
          status_q <= ST_FAIL;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_inc;
          if (enough) phase_q <= PH_WAIT;
        end
      end
    end
  end

  assign disp_valid  = (phase_q == PH_WAIT);
  assign disp_code   = cur_q;
  assign disp_nwords = cnt_q;
  assign cmd_status  = status_q;
  assign wr_err      = err_q;
endmodule

// File: rtl/cmd_dispatch_chk.sv
module cmd_dispatch_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_wr,
  input logic [ID_W-1:0] cmd_id,
  input logic            dat_wr,
  input logic            disp_valid,
  input logic            disp_ready,
  input logic [ID_W-1:0] disp_code,
  input logic [31:0]     disp_result,
  input logic [31:0]     cmd_status,
  input logic            wr_err
);
  import cmdc_pkg::*;

  logic id_legal;
  assign id_legal = (cmd_id != ID_W'(OP_IDLE)) && (cmd_id < ID_W'(OP_LIMIT));

  // R6
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_code));

  // R7
  take_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_ready |=> !disp_valid && cmd_status == $past(disp_result));

  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && (cmd_wr || dat_wr) |=> wr_err);

  // R9
  wait_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> $stable(cmd_status));

  // R3
  bad_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_valid && cmd_wr && !id_legal |=> cmd_status == ST_FAIL && !disp_valid);

  // R2
  good_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_valid && cmd_wr && id_legal |=> cmd_status == ST_SHORT);
endmodule

bind cmd_dispatch cmd_dispatch_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_id(cmd_id), .dat_wr(dat_wr),
  .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_code(disp_code),
  .disp_result(disp_result), .cmd_status(cmd_status), .wr_err(wr_err)
);

// File: tb/sim_cmd_dispatch.sv
module sim_cmd_dispatch;
  localparam int CLK_NS    = 10;
  localparam int ID_W      = 8;
  localparam int BUF_WORDS = 20;
  localparam int CNT_W     = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [ID_W-1:0] cmd_id = '0;
  logic dat_wr = 1'b0;
  logic [31:0] dat_word = '0;
  logic disp_valid;
  logic disp_ready = 1'b0;
  logic [ID_W-1:0] disp_code;
  logic [CNT_W-1:0] disp_nwords;
  logic [BUF_WORDS*32-1:0] disp_words;
  logic [31:0] disp_result = '0;
  logic [31:0] cmd_status;
  logic wr_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  cmd_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_id(cmd_id), .dat_wr(dat_wr),
    .dat_word(dat_word), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_code(disp_code), .disp_nwords(disp_nwords), .disp_words(disp_words),
    .disp_result(disp_result), .cmd_status(cmd_status), .wr_err(wr_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [ID_W-1:0] id);
    @(negedge clk); cmd_wr = 1'b1; cmd_id = id;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [31:0] w);
    @(negedge clk); dat_wr = 1'b1; dat_word = w;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic accept(input logic [31:0] res);
    @(negedge clk); disp_ready = 1'b1; disp_result = res;
    @(negedge clk); disp_ready = 1'b0;
  endtask

  function automatic logic [31:0] word_at(input int k);
    return disp_words[k*32 +: 32];
  endfunction

  task automatic t_reset();
    chk("R1 status", cmd_status, 32'h0);
    chk("R1 valid", {31'b0, disp_valid}, 32'h0);
    chk("R1 err", {31'b0, wr_err}, 32'h0);
  endtask

  task automatic t_bad_ids();
    wr_cmd(8'd0);
    chk("R3 id0 status", cmd_status, 32'h1);
    chk("R3 id0 valid", {31'b0, disp_valid}, 32'h0);
    wr_cmd(8'd10);
    chk("R3 id10 status", cmd_status, 32'h1);
    wr_cmd(8'hFF);
    chk("R3 idFF valid", {31'b0, disp_valid}, 32'h0);
  endtask

  task automatic t_zero_payload();
    wr_cmd(8'd6);
    chk("R4 valid", {31'b0, disp_valid}, 32'h1);
    chk("R4 code", 32'(disp_code), 32'd6);
    chk("R4 nwords", 32'(disp_nwords), 32'd0);
    chk("R2 status short", cmd_status, 32'hFFFF_FFFF);
    accept(32'h5A);
    chk("R7 status", cmd_status, 32'h5A);
    chk("R7 valid low", {31'b0, disp_valid}, 32'h0);
    wr_dat(32'h1234);
    chk("R7 idle after", cmd_status, 32'h1);
    wr_cmd(8'd8);
    chk("R4 adapter reset", 32'(disp_code), 32'd8);
    accept(32'h0);
  endtask

  task automatic t_idle_data();
    wr_dat(32'hABCD);
    chk("R8 status", cmd_status, 32'h1);
    chk("R8 valid", {31'b0, disp_valid}, 32'h0);
  endtask

  task automatic t_config_hold();
    wr_cmd(8'd1);
    chk("R2 status", cmd_status, 32'hFFFF_FFFF);
    for (int i = 0; i < 5; i++) wr_dat(32'hC000_0000 + 32'(i));
    chk("R5 not yet at 5", {31'b0, disp_valid}, 32'h0);
    wr_dat(32'hC000_0005);
    chk("R5 valid at 6", {31'b0, disp_valid}, 32'h1);
    chk("R5 nwords", 32'(disp_nwords), 32'd6);
    chk("R5 word0", word_at(0), 32'hC000_0000);
    chk("R5 word5", word_at(5), 32'hC000_0005);
    repeat (3) @(negedge clk);
    chk("R6 held", {31'b0, disp_valid}, 32'h1);
    chk("R6 code", 32'(disp_code), 32'd1);
    wr_dat(32'hDEAD);
    chk("R9 err data", {31'b0, wr_err}, 32'h1);
    chk("R9 nwords kept", 32'(disp_nwords), 32'd6);
    chk("R9 word5 kept", word_at(5), 32'hC000_0005);
    @(negedge clk);
    chk("R9 err pulse ends", {31'b0, wr_err}, 32'h0);
    wr_cmd(8'd4);
    chk("R9 err cmd", {31'b0, wr_err}, 32'h1);
    chk("R9 code kept", 32'(disp_code), 32'd1);
    chk("R9 status kept", cmd_status, 32'hFFFF_FFFF);
    accept(32'h0);
    chk("R7 ok", cmd_status, 32'h0);
  endtask

  task automatic t_restart();
    wr_cmd(8'd9);
    wr_dat(32'h9000_0000);
    wr_dat(32'h9000_0001);
    wr_cmd(8'd5);
    chk("R10 status", cmd_status, 32'hFFFF_FFFF);
    wr_dat(32'h5000_0000);
    wr_dat(32'h5000_0001);
    chk("R10 no early dispatch", {31'b0, disp_valid}, 32'h0);
    wr_dat(32'h5000_0002);
    chk("R10 dispatch", {31'b0, disp_valid}, 32'h1);
    chk("R10 code", 32'(disp_code), 32'd5);
    chk("R10 word0", word_at(0), 32'h5000_0000);
    accept(32'h1);
    chk("R7 fail result", cmd_status, 32'h1);
  endtask

  task automatic t_priority();
    wr_cmd(8'd1);
    @(negedge clk); cmd_wr = 1'b1; cmd_id = 8'd9; dat_wr = 1'b1; dat_word = 32'hBAD0;
    @(negedge clk); cmd_wr = 1'b0; dat_wr = 1'b0;
    chk("R11 no err", {31'b0, wr_err}, 32'h0);
    chk("R11 status", cmd_status, 32'hFFFF_FFFF);
    wr_dat(32'hA0);
    wr_dat(32'hA1);
    chk("R11 not yet", {31'b0, disp_valid}, 32'h0);
    wr_dat(32'hA2);
    chk("R11 code", 32'(disp_code), 32'd9);
    chk("R11 nwords", 32'(disp_nwords), 32'd3);
    chk("R11 word0", word_at(0), 32'hA0);
    accept(32'h0);
  endtask

  task automatic t_ring_full();
    wr_cmd(8'd4);
    for (int i = 0; i < 19; i++) wr_dat(32'h4400_0000 + 32'(i));
    chk("R5 ring not yet", {31'b0, disp_valid}, 32'h0);
    wr_dat(32'h4400_0013);
    chk("R5 ring valid", {31'b0, disp_valid}, 32'h1);
    chk("R5 ring nwords", 32'(disp_nwords), 32'd20);
    chk("R5 ring last", word_at(19), 32'h4400_0013);
    chk("R5 ring word7", word_at(7), 32'h4400_0007);
    accept(32'h0);
    wr_cmd(8'd7);
    for (int i = 0; i < 5; i++) wr_dat(32'h7700_0000 + 32'(i));
    chk("R5 msg ring at 5", 32'(disp_nwords), 32'd5);
    chk("R5 msg ring code", 32'(disp_code), 32'd7);
    accept(32'h0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_data();
    t_bad_ids();
    t_zero_payload();
    t_config_hold();
    t_restart();
    t_priority();
    t_ring_full();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule